// File: doc/BRIEF.md
# LVDS Lane Mapper

This block turns one parallel pixel per pixel clock (24 colour bits plus horizontal sync, vertical sync and data-enable) into seven-bit words for the data lanes of up to two LVDS channels. It also produces the word for each channel's clock lane. Each data lane carries seven bit slots per pixel clock. Every slot takes its bit from a source vector through its own programmable 5-bit index. The index can point at any colour bit, any of the three sync/enable bits, or a constant zero. A 7:1 shift stage running at seven times the pixel rate takes the words downstream, sending slot 6 first.

A simple write port programs the slot maps and an interface control word. The control word holds per-lane enables for both channels, per-channel clock-lane enables, an 18-bit (three data lanes) mode, single-channel mode, channel swap and a global enable. A separate serialize-enable bit releases the outputs. The outputs are released only after the lane configuration has been left alone for a settling interval, which is about 1 µs at the default pixel clock. Until then every lane sends all zeros.

Top module: `lvds_lane_mapper`

## Requirements
- R1: After reset every output is zero, serialize-enable and the control word are zero, and the slot maps hold the 24-bit default. For slots 0 to 6 the defaults are: lane 0 sources 8,5,4,3,2,1,0; lane 1 sources 0x11,0x10,0x0d,0x0c,0x0b,0x0a,0x09; lane 2 sources 0x1a,0x19,0x18,0x15,0x14,0x13,0x12; lane 3 sources 0x1b,0x17,0x16,0x0f,0x0e,0x07,0x06.
- R2: Output registers update on the clock edge that samples the pixel. Bit k of lane L's word (bits 7L+6..7L of a channel bus) equals source bit sel[L][k]. The source vector is colour bits 0..23 at indices 0..23, hsync at 24, vsync at 25 and data-enable at 26; indices 27 to 31 give zero. Word bit 6 is the first bit on the wire.
- R3: A write to address 2L sets lane L slots 0..3 from data bits [4:0], [9:5], [14:10], [19:15]. A write to address 2L+1 sets slots 4..6 from bits [4:0], [9:5], [14:10].
- R4: Address 8 is the control word. Its bits are: [3:0] channel-1 data lane enables, [7:4] channel-2 data lane enables, [8] and [9] channel-1 and channel-2 clock-lane enables, [10] 18-bit mode, [11] single channel, [12] swap, [13] global enable. A disabled data lane outputs all zeros.
- R5: In 18-bit mode lane 3 of both channels outputs zero whatever its enable.
- R6: In single-channel mode channel 2's data and clock lanes output zero.
- R7: An enabled, released clock lane outputs 7'b1100011 on every pixel clock; otherwise it outputs zero.
- R8: With swap set, the channel-1 output ports carry channel 2's lanes and the channel-2 ports carry channel 1's lanes.
- R9: With the global enable clear, all outputs stay zero however long the configuration is left alone.
- R10: Address 9 bit 0 is serialize-enable. A pixel sampled at the K-th edge after the last write to addresses 0 to 8 is sent only if K > SETTLE_CYCLES and serialize-enable was set at an earlier edge. Otherwise all outputs are zero.
- R11: Writes to addresses 10 to 15 change no state and do not restart the settling interval.
- R12: Clearing serialize-enable idles the outputs from the next pixel. Setting it again with no lane or control write in between resumes output at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pixRgb | input | 24 | Colour bits of the pixel |
| pixHsync | input | 1 | Horizontal sync |
| pixVsync | input | 1 | Vertical sync |
| pixDe | input | 1 | Data enable |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgAddr | input | 4 | Configuration address |
| cfgWrData | input | 20 | Configuration write data |
| ch1Data | output | 28 | Channel-1 data lane words, lane L at bits 7L+6..7L |
| ch2Data | output | 28 | Channel-2 data lane words, same layout |
| ch1Clk | output | 7 | Channel-1 clock-lane word |
| ch2Clk | output | 7 | Channel-2 clock-lane word |

## Verification
The hardest case to reach from the ports is the boundary of the settling interval. The outputs must go live on exactly the pixel after SETTLE_CYCLES quiet edges, and ignored writes must not restart the count. The stimulus writes a configuration, leaves it idle for slightly more than the interval and streams random pixels across the release edge. It then writes to unused addresses and toggles serialize-enable while live. A behavioural model tracks the settle count and compares every output on every clock.

// File: rtl/lvds_map_pkg.sv
package lvds_map_pkg;
  localparam int LANE_NUM = 4;
  localparam int SLOT_NUM = 7;
  localparam int SEL_W    = 5;
  localparam int CH_NUM   = 2;
  localparam int RGB_W    = 24;
  localparam int SRC_W    = 1 << SEL_W;
  localparam int CFG_AW   = 4;
  localparam int CFG_DW   = 4 * SEL_W;
  localparam int WORD_W   = LANE_NUM * SLOT_NUM;
  localparam logic [CFG_AW-1:0] ADDR_CTRL = CFG_AW'(2 * LANE_NUM);
  localparam logic [CFG_AW-1:0] ADDR_SER  = CFG_AW'(2 * LANE_NUM + 1);
  localparam logic [SLOT_NUM-1:0] CLK_PATTERN = 7'b1100011;

  typedef logic [SEL_W-1:0] sel_t;

  typedef struct packed {
    logic outEnable;
    logic rgb18;
    logic single;
    logic swap;
    logic [CH_NUM-1:0][LANE_NUM-1:0] dataEn;
    logic [CH_NUM-1:0] clkEn;
  } strb_t;

  // reset map, slot 0 in the low field of each row
  function automatic sel_t defaultSel(int lane, int slot);
    logic [SLOT_NUM*SEL_W-1:0] row;
    case (lane)
      0: row = {5'h00, 5'h01, 5'h02, 5'h03, 5'h04, 5'h05, 5'h08};
      1: row = {5'h09, 5'h0a, 5'h0b, 5'h0c, 5'h0d, 5'h10, 5'h11};
      2: row = {5'h12, 5'h13, 5'h14, 5'h15, 5'h18, 5'h19, 5'h1a};
      3: row = {5'h06, 5'h07, 5'h0e, 5'h0f, 5'h16, 5'h17, 5'h1b};
      default: row = '0;
    endcase
    return row[slot*SEL_W +: SEL_W];
  endfunction
endpackage

// File: rtl/lvds_map_ctrl.sv
module lvds_map_ctrl
  import lvds_map_pkg::*;
#(
  parameter int SETTLE_CYCLES = 250
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                cfgWrEn,
  input  logic [CFG_AW-1:0]                   cfgAddr,
  input  logic [CFG_DW-1:0]                   cfgWrData,
  output sel_t [LANE_NUM-1:0][SLOT_NUM-1:0]   slotSel,
  output strb_t                               strb
);
  localparam int CNT_W = $clog2(SETTLE_CYCLES + 1);
  localparam logic [CNT_W-1:0] SETTLE_LIM = CNT_W'(SETTLE_CYCLES);
  localparam int CTRL_W = 14;

  sel_t [LANE_NUM-1:0][SLOT_NUM-1:0] selReg;
  logic [CTRL_W-1:0] ctrlReg;
  logic              serEnReg;
  logic [CNT_W-1:0]  settleCnt;

  logic laneWr, ctrlWr, serWr, cfgTouch;
  assign laneWr   = cfgWrEn && (cfgAddr < ADDR_CTRL);
  assign ctrlWr   = cfgWrEn && (cfgAddr == ADDR_CTRL);
  assign serWr    = cfgWrEn && (cfgAddr == ADDR_SER);
  assign cfgTouch = laneWr || ctrlWr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int l = 0; l < LANE_NUM; l++)
        for (int s = 0; s < SLOT_NUM; s++)
          selReg[l][s] <= defaultSel(l, s);
    end else if (laneWr) begin
      for (int l = 0; l < LANE_NUM; l++)
        for (int s = 0; s < SLOT_NUM; s++)
          if (cfgAddr == CFG_AW'(2 * l + s / 4))
            selReg[l][s] <= cfgWrData[(s % 4) * SEL_W +: SEL_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrlReg  <= '0;
      serEnReg <= 1'b0;
    end else begin
      if (ctrlWr) ctrlReg  <= cfgWrData[CTRL_W-1:0];
      if (serWr)  serEnReg <= cfgWrData[0];
    end
  end

  // settle timer restarts on every lane or control write and saturates
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     settleCnt <= '0;
    else if (cfgTouch)              settleCnt <= '0;
    else if (settleCnt != SETTLE_LIM) settleCnt <= settleCnt + CNT_W'(1);
  end

  assign slotSel        = selReg;
  assign strb.outEnable = serEnReg && ctrlReg[13] && (settleCnt == SETTLE_LIM);
  assign strb.swap      = ctrlReg[12];
  assign strb.single    = ctrlReg[11];
  assign strb.rgb18     = ctrlReg[10];
  assign strb.clkEn     = ctrlReg[9:8];
  assign strb.dataEn    = {ctrlReg[7:4], ctrlReg[3:0]};
endmodule

// File: rtl/lvds_map_datapath.sv
module lvds_map_datapath
  import lvds_map_pkg::*;
(
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [RGB_W-1:0]                   pixRgb,
  input  logic                               pixHsync,
  input  logic                               pixVsync,
  input  logic                               pixDe,
  input  strb_t                              strb,
  input  sel_t [LANE_NUM-1:0][SLOT_NUM-1:0]  slotSel,
  output logic [WORD_W-1:0]                  ch1Data,
  output logic [WORD_W-1:0]                  ch2Data,
  output logic [SLOT_NUM-1:0]                ch1Clk,
  output logic [SLOT_NUM-1:0]                ch2Clk
);
  logic [SRC_W-1:0] srcVec;
  logic [LANE_NUM-1:0][SLOT_NUM-1:0] laneWord;
  logic [CH_NUM-1:0][LANE_NUM-1:0][SLOT_NUM-1:0] chWord;
  logic [CH_NUM-1:0][SLOT_NUM-1:0] chClk;

  assign srcVec = {{(SRC_W - RGB_W - 3){1'b0}}, pixDe, pixVsync, pixHsync, pixRgb};

  for (genvar l = 0; l < LANE_NUM; l++) begin : g_lane
    for (genvar s = 0; s < SLOT_NUM; s++) begin : g_slot
      assign laneWord[l][s] = srcVec[slotSel[l][s]];
    end
  end

  for (genvar c = 0; c < CH_NUM; c++) begin : g_ch
    logic chLive;
    if (c == 0) begin : g_pri
      assign chLive = strb.outEnable;
    end else begin : g_sec
      assign chLive = strb.outEnable && !strb.single;
    end
    assign chClk[c] = (chLive && strb.clkEn[c]) ? CLK_PATTERN : '0;
    for (genvar l = 0; l < LANE_NUM; l++) begin : g_out
      if (l == LANE_NUM - 1) begin : g_top
        assign chWord[c][l] = (chLive && strb.dataEn[c][l] && !strb.rgb18) ? laneWord[l] : '0;
      end else begin : g_low
        assign chWord[c][l] = (chLive && strb.dataEn[c][l]) ? laneWord[l] : '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ch1Data <= '0;
      ch2Data <= '0;
      ch1Clk  <= '0;
      ch2Clk  <= '0;
    end else if (strb.swap) begin
      ch1Data <= chWord[1];
      ch2Data <= chWord[0];
      ch1Clk  <= chClk[1];
      ch2Clk  <= chClk[0];
    end else begin
      ch1Data <= chWord[0];
      ch2Data <= chWord[1];
      ch1Clk  <= chClk[0];
      ch2Clk  <= chClk[1];
    end
  end
endmodule

// File: rtl/lvds_lane_mapper.sv
module lvds_lane_mapper
  import lvds_map_pkg::*;
#(
  parameter int SETTLE_CYCLES = 250
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [RGB_W-1:0]     pixRgb,
  input  logic                 pixHsync,
  input  logic                 pixVsync,
  input  logic                 pixDe,
  input  logic                 cfgWrEn,
  input  logic [CFG_AW-1:0]    cfgAddr,
  input  logic [CFG_DW-1:0]    cfgWrData,
  output logic [WORD_W-1:0]    ch1Data,
  output logic [WORD_W-1:0]    ch2Data,
  output logic [SLOT_NUM-1:0]  ch1Clk,
  output logic [SLOT_NUM-1:0]  ch2Clk
);
  strb_t ctrlStrb;
  sel_t [LANE_NUM-1:0][SLOT_NUM-1:0] slotSel;

  lvds_map_ctrl #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .cfgWrData(cfgWrData), .slotSel(slotSel), .strb(ctrlStrb)
  );

  lvds_map_datapath u_dp (
    .clk(clk), .rst_n(rst_n), .pixRgb(pixRgb), .pixHsync(pixHsync),
    .pixVsync(pixVsync), .pixDe(pixDe), .strb(ctrlStrb), .slotSel(slotSel),
    .ch1Data(ch1Data), .ch2Data(ch2Data), .ch1Clk(ch1Clk), .ch2Clk(ch2Clk)
  );
endmodule

// File: rtl/lvds_lane_mapper_chk.sv
module lvds_lane_mapper_chk
  import lvds_map_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic                cfgWrEn,
  input logic [CFG_AW-1:0]   cfgAddr,
  input strb_t               strb,
  input logic [WORD_W-1:0]   ch1Data,
  input logic [WORD_W-1:0]   ch2Data,
  input logic [SLOT_NUM-1:0] ch1Clk,
  input logic [SLOT_NUM-1:0] ch2Clk
);
  assert_clk_pattern_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ch1Clk == '0 || ch1Clk == CLK_PATTERN) && (ch2Clk == '0 || ch2Clk == CLK_PATTERN));

  assert_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.outEnable |=> (ch1Data == '0 && ch2Data == '0 && ch1Clk == '0 && ch2Clk == '0));

  assert_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cfgWrEn && cfgAddr <= ADDR_CTRL) |=> !strb.outEnable);

  assert_lane3_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    strb.rgb18 |=> (ch1Data[WORD_W-1 -: SLOT_NUM] == '0 && ch2Data[WORD_W-1 -: SLOT_NUM] == '0));

  assert_second_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.single && !strb.swap) |=> (ch2Data == '0 && ch2Clk == '0));

  assert_ignored_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cfgWrEn && cfgAddr > ADDR_SER) |=>
      $stable({strb.rgb18, strb.single, strb.swap, strb.dataEn, strb.clkEn}));
endmodule

bind lvds_lane_mapper lvds_lane_mapper_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
  .strb(ctrlStrb), .ch1Data(ch1Data), .ch2Data(ch2Data),
  .ch1Clk(ch1Clk), .ch2Clk(ch2Clk)
);

// File: tb/lvds_lane_mapper_bench.sv
module lvds_lane_mapper_bench;
  localparam int SETTLE = 250;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] pixRgb = '0;
  logic        pixHsync = 1'b0, pixVsync = 1'b0, pixDe = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [3:0]  cfgAddr = '0;
  logic [19:0] cfgWrData = '0;
  logic [27:0] ch1Data, ch2Data;
  logic [6:0]  ch1Clk, ch2Clk;

  int nVec = 0;
  int nFail = 0;
  string curReq = "R1";
  bit started = 1'b0;

  always #2 clk = ~clk;

  lvds_lane_mapper u_lvds_lane_mapper (
    .clk(clk), .rst_n(rst_n), .pixRgb(pixRgb), .pixHsync(pixHsync),
    .pixVsync(pixVsync), .pixDe(pixDe), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .cfgWrData(cfgWrData), .ch1Data(ch1Data), .ch2Data(ch2Data),
    .ch1Clk(ch1Clk), .ch2Clk(ch2Clk)
  );

  // ---------------- behavioural reference model ----------------
  int   msel [4][7];
  bit [3:0] mEn [2];
  bit   mClkEn [2];
  bit   mRgb18, mSingle, mSwap, mGlobal, mSer;
  int   mCnt;
  logic [27:0] expD [2];
  logic [6:0]  expC [2];

  function automatic bit srcBit(int idx, logic [23:0] rgb, logic hs, logic vs, logic de);
    if (idx < 24) return rgb[idx];
    if (idx == 24) return hs;
    if (idx == 25) return vs;
    if (idx == 26) return de;
    return 1'b0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      msel[0] = '{8, 5, 4, 3, 2, 1, 0};
      msel[1] = '{'h11, 'h10, 'h0d, 'h0c, 'h0b, 'h0a, 'h09};
      msel[2] = '{'h1a, 'h19, 'h18, 'h15, 'h14, 'h13, 'h12};
      msel[3] = '{'h1b, 'h17, 'h16, 'h0f, 'h0e, 'h07, 'h06};
      mEn[0] = '0; mEn[1] = '0; mClkEn[0] = 0; mClkEn[1] = 0;
      mRgb18 = 0; mSingle = 0; mSwap = 0; mGlobal = 0; mSer = 0; mCnt = 0;
      expD[0] = '0; expD[1] = '0; expC[0] = '0; expC[1] = '0;
    end else begin
      logic [27:0] lw [2];
      logic [6:0]  lc [2];
      bit rdy;
      rdy = mSer && mGlobal && (mCnt >= SETTLE);
      for (int c = 0; c < 2; c++) begin
        bit chOn;
        chOn = rdy && !(c == 1 && mSingle);
        lw[c] = '0;
        for (int l = 0; l < 4; l++) begin
          bit on;
          on = chOn && mEn[c][l] && !(l == 3 && mRgb18);
          for (int s = 0; s < 7; s++)
            lw[c][l*7+s] = on ? srcBit(msel[l][s], pixRgb, pixHsync, pixVsync, pixDe) : 1'b0;
        end
        lc[c] = (chOn && mClkEn[c]) ? 7'b1100011 : 7'b0;
      end
      expD[0] = mSwap ? lw[1] : lw[0];
      expD[1] = mSwap ? lw[0] : lw[1];
      expC[0] = mSwap ? lc[1] : lc[0];
      expC[1] = mSwap ? lc[0] : lc[1];
      // configuration update after the output is formed
      if (cfgWrEn && cfgAddr < 8) begin
        int ln;
        ln = cfgAddr / 2;
        if (cfgAddr % 2 == 0)
          for (int s = 0; s < 4; s++) msel[ln][s] = int'(cfgWrData[s*5 +: 5]);
        else
          for (int s = 4; s < 7; s++) msel[ln][s] = int'(cfgWrData[(s-4)*5 +: 5]);
        mCnt = 0;
      end else if (cfgWrEn && cfgAddr == 8) begin
        mEn[0] = cfgWrData[3:0]; mEn[1] = cfgWrData[7:4];
        mClkEn[0] = cfgWrData[8]; mClkEn[1] = cfgWrData[9];
        mRgb18 = cfgWrData[10]; mSingle = cfgWrData[11];
        mSwap = cfgWrData[12]; mGlobal = cfgWrData[13];
        mCnt = 0;
      end else begin
        if (cfgWrEn && cfgAddr == 9) mSer = cfgWrData[0];
        if (mCnt < SETTLE) mCnt++;
      end
    end
    started = 1'b1;
  end

  // per-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (started) begin
      nVec++;
      if (ch1Data !== expD[0] || ch2Data !== expD[1] || ch1Clk !== expC[0] || ch2Clk !== expC[1]) begin
        nFail++;
        $display("FAIL %s actual=%h/%h/%h/%h expected=%h/%h/%h/%h", curReq,
                 ch1Data, ch2Data, ch1Clk, ch2Clk, expD[0], expD[1], expC[0], expC[1]);
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic tickPix(input bit we, input logic [3:0] a, input logic [19:0] d,
                         input logic [23:0] rgb, input logic hs, input logic vs, input logic de);
    @(negedge clk);
    cfgWrEn = we; cfgAddr = a; cfgWrData = d;
    pixRgb = rgb; pixHsync = hs; pixVsync = vs; pixDe = de;
  endtask

  task automatic tick(input bit we, input logic [3:0] a, input logic [19:0] d);
    logic [2:0] sy;
    sy = 3'($urandom);
    tickPix(we, a, d, 24'($urandom), sy[0], sy[1], sy[2]);
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) tick(1'b0, 4'd0, 20'd0);
  endtask

  task automatic wr(input logic [3:0] a, input logic [19:0] d);
    tick(1'b1, a, d);
  endtask

  task automatic direct(input string req, input logic [27:0] act, input logic [27:0] exp);
    nVec++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [19:0] ctl(input logic [3:0] e1, input logic [3:0] e2, input logic c1,
      input logic c2, input logic r18, input logic sg, input logic sw, input logic gl);
    return {6'b0, gl, sw, sg, r18, c2, c1, e2, e1};
  endfunction

  function automatic logic [19:0] lo(input int s0, input int s1, input int s2, input int s3);
    return {5'(s3), 5'(s2), 5'(s1), 5'(s0)};
  endfunction

  function automatic logic [19:0] hi(input int s4, input int s5, input int s6);
    return {5'b0, 5'(s6), 5'(s5), 5'(s4)};
  endfunction

  // ---------------- watchdog ----------------
  initial begin
    #(200000 * 4);
    nFail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nFail);
    $finish;
  end

  // ---------------- scenario ----------------
  initial begin
    curReq = "R1";
    repeat (5) @(negedge clk);
    direct("R1", ch1Data | ch2Data, 28'h0);
    direct("R1", {14'b0, ch1Clk, ch2Clk}, 28'h0);
    rst_n = 1'b1;
    run(3);

    // R4: partial lane enables, single channel
    curReq = "R10";
    wr(4'd8, ctl(4'h5, 4'h0, 1, 0, 0, 1, 0, 1));
    wr(4'd9, 20'd1);
    run(SETTLE + 2);
    curReq = "R4";
    run(20);

    // R2 and R7 with the default map on all four lanes
    curReq = "R10";
    wr(4'd8, ctl(4'hF, 4'h0, 1, 0, 0, 1, 0, 1));
    run(SETTLE + 2);
    curReq = "R2";
    tickPix(1'b0, 4'd0, 20'd0, 24'h000100, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    direct("R2", ch1Data, 28'h0000001);
    direct("R7", {21'b0, ch1Clk}, {21'b0, 7'b1100011});
    curReq = "R7";
    run(30);

    // R3: reprogram lanes 0 and 3, including sync and zero sources
    curReq = "R3";
    wr(4'd0, lo('h0a, 7, 6, 5));
    wr(4'd1, hi(4, 3, 2));
    wr(4'd6, lo(24, 25, 26, 27));
    wr(4'd7, hi(31, 0, 23));
    run(SETTLE + 40);
    tickPix(1'b0, 4'd0, 20'd0, 24'h800001, 1'b1, 1'b0, 1'b1);
    @(negedge clk);
    direct("R3", {ch1Data[27:21], 21'b0}, {7'b1100101, 21'b0});

    // R11: unused addresses neither change state nor restart settling
    curReq = "R11";
    wr(4'd12, 20'hFFFFF);
    wr(4'd15, 20'h00000);
    run(10);

    // R12: serialize-enable off then on with no lane write in between
    curReq = "R12";
    wr(4'd9, 20'd0);
    run(5);
    wr(4'd9, 20'd1);
    run(10);

    // R5: 18-bit mode, both channels
    curReq = "R5";
    wr(4'd8, ctl(4'hF, 4'hF, 1, 1, 1, 0, 0, 1));
    run(SETTLE + 30);

    // R6: single channel with channel 2 lanes requested
    curReq = "R6";
    wr(4'd8, ctl(4'hF, 4'hF, 1, 1, 0, 1, 0, 1));
    run(SETTLE + 30);

    // R8: swapped channels with different lane sets
    curReq = "R8";
    wr(4'd8, ctl(4'h3, 4'hC, 1, 0, 0, 0, 1, 1));
    run(SETTLE + 30);

    // R9: global enable off, long quiet period
    curReq = "R9";
    wr(4'd8, ctl(4'hF, 4'hF, 1, 1, 0, 0, 0, 0));
    run(SETTLE + 30);
    direct("R9", ch1Data | ch2Data, 28'h0);

    @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nFail);
    $finish;
  end
endmodule